// File: doc/BRIEF.md
# Split Radix-4 Array Multiplier

This block multiplies two signed N-bit operands in two's complement and returns the exact signed 2N-bit product. The multiplier operand is recoded into radix-4 digits, each selecting zero, plus or minus one times the multiplicand, or plus or minus two times it. The digits are handled from the most significant one downwards. The resulting rows are cut into two groups. Each group is summed by its own chain of carry-save adders, and the two groups are processed side by side.

The two carry-save pairs go through a single four-to-two compression level. A Kogge-Stone prefix adder then resolves the result. Whenever a digit is negative, the row is inverted and a one is injected at that row's least significant column. These injection bits share one extra vector that travels with the lower group.

The datapath itself is purely combinational. An optional output register, selected by a parameter, makes the product available one clock after the operands and clears it while reset is low. N must be even and between 4 and 32.

Top module: `split_booth_mul`

## Requirements
- R1: For any operands, `prod_out` equals the signed product of `a_in` and `b_in` as a 2N-bit two's complement value.
- R2: The most negative operand times itself gives 2^(2N-2), a positive value with bit 2N-2 set and all other bits clear.
- R3: When either operand is zero, the product is zero.
- R4: A multiplier of +1 returns the multiplicand sign-extended to 2N bits.
- R5: A multiplier with all bits set (value -1) returns the negated multiplicand in 2N bits; for the most negative multiplicand this gives +2^(N-1).
- R6: When both operands are non-zero, the product's top bit equals the XOR of the two operand sign bits.
- R7: The four-to-two merge stage keeps the arithmetic sum of its four input vectors modulo 2^(2N).
- R8: With `OUT_REG`=1, `prod_out` is 0 while `rst_n` is low, and otherwise it shows the product of the operands present at the previous rising clock edge. With `OUT_REG`=0, it follows the operands combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_in | input | N | Multiplicand, signed two's complement |
| b_in | input | N | Multiplier, signed two's complement, recoded in radix 4 |
| prod_out | output | 2N | Signed product |

## Verification
The bench builds four copies side by side, all with the output register on: N = 8, 10, 16 and 32. N = 10 has an odd number of radix-4 digits, so it exercises the uneven split in which the upper group holds one more row than the lower. The even sizes cover balanced groups. N = 32 reaches the widest prefix network and the largest magnitudes, and N = 8 makes the extreme operand pairs dense among the random vectors.

// File: rtl/split_booth_mul.sv
module split_booth_mul #(
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a_in,
  input  logic [N-1:0]   b_in,
  output logic [2*N-1:0] prod_out
);
  localparam int W  = 2 * N;
  localparam int ND = N / 2;
  localparam int NU = (ND + 1) / 2;
  localparam int M  = W - 1;
  localparam int LG = $clog2(M);

  logic [N:0]    ybits;
  logic [W-1:0]  row [ND];
  logic [ND-1:0] negd;
  logic [W-1:0]  hot;
  logic [W-1:0]  us, uc, ls, lc;
  logic [W-1:0]  t42, k42, ci42, m42, s42, c42;
  logic [W-1:0]  cy, prod_c;

  assign ybits = {b_in, 1'b0};

  for (genvar j = 0; j < ND; j++) begin : g_rec
    localparam int I = ND - 1 - j;
    logic [2:0] trip;
    logic       one_w, two_w;
    logic [N:0] mag, sel;
    assign trip    = ybits[2*I+2 : 2*I];
    assign one_w   = trip[1] ^ trip[0];
    assign two_w   = (trip == 3'b100) || (trip == 3'b011);
    assign negd[I] = trip[2];
    assign mag     = one_w ? {a_in[N-1], a_in} : (two_w ? {a_in, 1'b0} : '0);
    assign sel     = mag ^ {(N+1){trip[2]}};
    assign row[j]  = {{(W-N-1){sel[N]}}, sel} << (2*I);
  end

  always_comb begin
    hot = '0;
    for (int i = 0; i < ND; i++) hot[2*i] = negd[i];
  end

  always_comb begin
    logic [W-1:0] s, c, x;
    s = row[0];
    c = '0;
    for (int k = 1; k < NU; k++) begin
      x = row[k];
      {s, c} = {s ^ c ^ x, ((s & c) | (s & x) | (c & x)) << 1};
    end
    us = s;
    uc = c;
    s = row[NU];
    c = hot;
    for (int k = NU + 1; k < ND; k++) begin
      x = row[k];
      {s, c} = {s ^ c ^ x, ((s & c) | (s & x) | (c & x)) << 1};
    end
    ls = s;
    lc = c;
  end

  assign t42  = us ^ uc ^ ls;
  assign k42  = (us & uc) | (us & ls) | (uc & ls);
  assign ci42 = {k42[W-2:0], 1'b0};
  assign s42  = t42 ^ lc ^ ci42;
  assign m42  = (t42 & lc) | (t42 & ci42) | (lc & ci42);
  assign c42  = {m42[W-2:0], 1'b0};

  always_comb begin
    logic [M-1:0] g, p, ng, np;
    g = s42[M-1:0] & c42[M-1:0];
    p = s42[M-1:0] ^ c42[M-1:0];
    for (int s = 0; s < LG; s++) begin
      ng = g;
      np = p;
      for (int b = 0; b < M; b++) begin
        if (b >= (1 << s)) begin
          ng[b] = g[b] | (p[b] & g[b - (1 << s)]);
          np[b] = p[b] & p[b - (1 << s)];
        end
      end
      g = ng;
      p = np;
    end
    cy = {g, 1'b0};
  end

  assign prod_c = s42 ^ c42 ^ cy;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) prod_out <= '0;
      else        prod_out <= prod_c;
    end
  end else begin : g_comb
    assign prod_out = prod_c;
  end

  logic [W-1:0] a_ext;
  assign a_ext = {{N{a_in[N-1]}}, a_in};

  p_min_square_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in == {1'b1, {(N-1){1'b0}}} && b_in == {1'b1, {(N-1){1'b0}}})
      |-> prod_c == (W'(1) << (W - 2)));

  p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in == '0 || b_in == '0) |-> prod_c == '0);

  p_unit_mult_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (b_in == N'(1)) |-> prod_c == a_ext);

  p_neg_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_in == '1) |-> prod_c == W'(-a_ext));

  p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in != '0 && b_in != '0) |-> prod_c[W-1] == (a_in[N-1] ^ b_in[N-1]));

  p_merge_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    W'(s42 + c42) == W'(us + uc + ls + lc));
endmodule

// File: tb/split_booth_mul_tb_top.sv
module split_booth_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   total = 0;
  int   bad = 0;
  int   done_cnt = 0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < 4; k++) begin : g_w
    localparam int NW = (k == 0) ? 8 : (k == 1) ? 10 : (k == 2) ? 16 : 32;
    localparam int WW = 2 * NW;
    localparam logic [NW-1:0] MINV = {1'b1, {(NW-1){1'b0}}};
    localparam logic [NW-1:0] MAXV = {1'b0, {(NW-1){1'b1}}};

    logic [NW-1:0] a = '1;
    logic [NW-1:0] b = '1;
    logic [WW-1:0] prod;
    logic [WW-1:0] expq[$];
    string         tagq[$];

    split_booth_mul #(.N(NW), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .prod_out(prod));

    function automatic logic [WW-1:0] ref_mul(logic [NW-1:0] x, logic [NW-1:0] y);
      logic [WW-1:0] sx, sy;
      sx = {{NW{x[NW-1]}}, x};
      sy = {{NW{y[NW-1]}}, y};
      return sx * sy;
    endfunction

    task automatic push(logic [NW-1:0] x, logic [NW-1:0] y, string tag);
      @(negedge clk);
      a = x;
      b = y;
      expq.push_back(ref_mul(x, y));
      tagq.push_back(tag);
    endtask

    initial begin
      logic [WW-1:0] e;
      string t;
      wait (rst_n);
      forever begin
        @(posedge clk);
        #1;
        if (expq.size() > 0) begin
          e = expq.pop_front();
          t = tagq.pop_front();
          total++;
          if (prod !== e) begin
            bad++;
            $display("FAIL %s N=%0d actual=%h expected=%h", t, NW, prod, e);
          end
        end
      end
    end

    initial begin
      repeat (3) @(negedge clk);
      total++;
      if (prod !== '0) begin
        bad++;
        $display("FAIL R8 reset N=%0d actual=%h expected=0", NW, prod);
      end
      wait (rst_n);
      push(MINV, MINV, "R2 min*min");
      push('0, MAXV, "R3 zero*max");
      push(MINV, '0, "R3 min*zero");
      push(MAXV, NW'(1), "R4 max*1");
      push(MINV, NW'(1), "R4 min*1");
      push(NW'(1), NW'(1), "R4 1*1");
      push(MINV, '1, "R5 min*-1");
      push(MAXV, '1, "R5 max*-1");
      push('1, '1, "R5 -1*-1");
      push(NW'(5), NW'(-3), "R6 pos*neg");
      push(NW'(-7), NW'(-9), "R6 neg*neg");
      push(MAXV, MAXV, "R6 max*max");
      push(MINV, MAXV, "R6 min*max");
      push({(NW/2){2'b10}}, {(NW/2){2'b01}}, "R1 alternating");
      push({(NW/2){2'b01}}, {(NW/2){2'b10}}, "R1 alternating swap");
      for (int r = 0; r < 10000; r++)
        push(NW'({$urandom(), $urandom()}), NW'({$urandom(), $urandom()}), "R1 R7 R8 random");
      @(negedge clk);
      a = '0;
      b = '0;
      wait (expq.size() == 0);
      done_cnt++;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait (done_cnt == 4);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 60000);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule